// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt factors arranged in groups of up to four. Each group owns one 16-bit control word. The word holds a shared 3-bit priority level, a per-factor enable mask, per-factor pending bits and a read-only view of which factors are both pending and enabled. Hardware sources set pending bits with single-cycle pulses. Software reads the words and clears pending bits through a simple register port.

On every clock the block checks which groups have an enabled pending factor and a level below the processor's current mask level. It picks one winner from those groups. The winner is the group with the numerically smallest level; if levels are equal, the lowest group number wins. The block then presents a registered request together with the winning group number and its level. The processor uses these to find the handler, which then clears the serviced bits.

Group 0 uses a write-one-to-clear convention for its pending bits. The other groups take a masked write, where the detect field of the written word selects which pending bits are written.

Top module: `irq_group_arbiter`

## Requirements
- R1: A group can win only when its level value is strictly less than `cpuMask`. When the level equals or exceeds the mask, the group is blocked.
- R2: Among eligible groups, the smallest level value wins. When levels tie, the smallest group number wins.
- R3: A factor counts only when both its pending bit and its enable bit are 1. Each read-back detect bit equals pending AND enable for that factor.
- R4: Reset clears every level, enable and pending bit. It also drives `irqOut`, `irqGroup` and `irqLevel` to 0.
- R5: A write to a group other than 0 sets each pending bit to the written pending value only where the written detect bit (bits 3:0) is 1. All other pending bits keep their value.
- R6: A write to group 0 clears each pending bit whose written detect bit is 1. A 0 in a detect bit leaves the matching pending bit unchanged.
- R7: A 1 on `hwReq[g*4+f]` sets pending bit f of group g on that clock edge. If software tries to clear the same bit on the same edge, the set wins.
- R8: The following all read as 0: group 1, and any address of 20 or more. Writes and hardware pulses aimed at these addresses have no effect.
- R9: `irqOut`, `irqGroup` and `irqLevel` update on the clock edge after the state they reflect. When no group qualifies, `irqOut` is 0 and both `irqGroup` and `irqLevel` are 0.
- R10: The control word layout is: bit 15 reads 0, level in bits 14:12, enable in bits 11:8, pending in bits 7:4, detect in bits 3:0. Level and enable take the written value on every accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Group number selected for read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read of the selected group word |
| hwReq | input | 80 | Hardware set pulses, four per group |
| cpuMask | input | 3 | Processor interrupt mask level |
| irqOut | output | 1 | Registered interrupt request |
| irqGroup | output | 5 | Winning group number |
| irqLevel | output | 3 | Level of the winning group |

## Verification
Suppose a pending or enable bit is wrong inside the block. It shows up right away as a wrong detect field on the next read of that group. Two clock edges after the stimulus, it also shows up as a wrong or missing request at the arbitration outputs. A wrong arbitration decision, such as a tie broken the wrong way or a level equal to the mask let through, appears as a wrong group or level on the first edge after the condition holds. Because every check samples both the read-back word and the outputs after each operation, a corrupted bit is caught within two cycles of the write or pulse that exposes it.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int LVL_W   = 3;
  localparam int FACT_N  = 4;
  localparam int GRP_W   = 5;
  localparam int DATA_W  = 16;
  localparam int DET_LSB = 0;
  localparam int REQ_LSB = DET_LSB + FACT_N;
  localparam int EN_LSB  = REQ_LSB + FACT_N;
  localparam int LVL_LSB = EN_LSB + FACT_N;

  // Strobes from the register decoder into the group datapath
  typedef struct packed {
    logic              wr;
    logic [GRP_W-1:0]  grp;
    logic [LVL_W-1:0]  lev;
    logic [FACT_N-1:0] en;
    logic [FACT_N-1:0] reqMask;
    logic [FACT_N-1:0] reqVal;
  } wrStrobe_t;
endpackage

// File: rtl/irq_grp_ctrl.sv
module irq_grp_ctrl
  import irq_grp_pkg::*;
#(
  parameter int NUM_GROUPS     = 20,
  parameter int RESERVED_GROUP = 1,
  parameter int CLEAR_GROUP    = 0
) (
  input  logic              wrEn,
  input  logic [GRP_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobe_t         strobe,
  output logic              rdHit
);
  logic addrLive;
  logic isClearGroup;
  logic [FACT_N-1:0] detField;
  logic unusedTopBit;

  assign addrLive     = (int'(regAddr) < NUM_GROUPS) && (int'(regAddr) != RESERVED_GROUP);
  assign isClearGroup = (int'(regAddr) == CLEAR_GROUP);
  assign detField     = wrData[DET_LSB +: FACT_N];
  assign unusedTopBit = wrData[DATA_W-1];
  assign rdHit        = addrLive;

  always_comb begin
    strobe.wr      = wrEn && addrLive;
    strobe.grp     = regAddr;
    strobe.lev     = wrData[LVL_LSB +: LVL_W];
    strobe.en      = wrData[EN_LSB +: FACT_N];
    strobe.reqMask = detField;
    // write-one-to-clear for the clear group, masked write elsewhere
    strobe.reqVal  = isClearGroup ? '0 : wrData[REQ_LSB +: FACT_N];
  end
endmodule

// File: rtl/irq_grp_datapath.sv
module irq_grp_datapath
  import irq_grp_pkg::*;
#(
  parameter int NUM_GROUPS     = 20,
  parameter int RESERVED_GROUP = 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  wrStrobe_t                    strobe,
  input  logic [NUM_GROUPS*FACT_N-1:0] hwReq,
  input  logic [LVL_W-1:0]             cpuMask,
  input  logic [GRP_W-1:0]             regAddr,
  input  logic                         rdHit,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irqOut,
  output logic [GRP_W-1:0]             irqGroup,
  output logic [LVL_W-1:0]             irqLevel
);
  logic [LVL_W-1:0]  lev [NUM_GROUPS];
  logic [FACT_N-1:0] en  [NUM_GROUPS];
  logic [FACT_N-1:0] req [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] elig;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    if (g == RESERVED_GROUP) begin : gRsv
      logic unusedHwBits;
      assign unusedHwBits = ^hwReq[g*FACT_N +: FACT_N];
      assign lev[g] = '0;
      assign en[g]  = '0;
      assign req[g] = '0;
    end else begin : gLive
      logic [LVL_W-1:0]  levQ;
      logic [FACT_N-1:0] enQ;
      logic [FACT_N-1:0] reqQ;
      logic [FACT_N-1:0] hwBits;
      logic              hit;
      assign hwBits = hwReq[g*FACT_N +: FACT_N];
      assign hit    = strobe.wr && (strobe.grp == GRP_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          levQ <= '0;
          enQ  <= '0;
          reqQ <= '0;
        end else if (hit) begin
          levQ <= strobe.lev;
          enQ  <= strobe.en;
          reqQ <= (reqQ & ~strobe.reqMask) | (strobe.reqVal & strobe.reqMask) | hwBits;
        end else begin
          reqQ <= reqQ | hwBits;
        end
      end
      assign lev[g] = levQ;
      assign en[g]  = enQ;
      assign req[g] = reqQ;
    end
    assign elig[g] = (|(req[g] & en[g])) && (lev[g] < cpuMask);
  end

  // register read
  always_comb begin
    rdData = '0;
    if (rdHit) begin
      rdData[LVL_LSB +: LVL_W]  = lev[regAddr];
      rdData[EN_LSB  +: FACT_N] = en[regAddr];
      rdData[REQ_LSB +: FACT_N] = req[regAddr];
      rdData[DET_LSB +: FACT_N] = req[regAddr] & en[regAddr];
    end
  end

  // arbitration: smaller level first, then lower group index
  logic             found;
  logic [LVL_W-1:0] bestLev;
  logic [GRP_W-1:0] bestGrp;
  always_comb begin
    found   = 1'b0;
    bestLev = '0;
    bestGrp = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (elig[g] && (!found || (lev[g] < bestLev))) begin
        found   = 1'b1;
        bestLev = lev[g];
        bestGrp = GRP_W'(g);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut   <= 1'b0;
      irqGroup <= '0;
      irqLevel <= '0;
    end else begin
      irqOut   <= found;
      irqGroup <= bestGrp;
      irqLevel <= bestLev;
    end
  end
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irq_grp_pkg::*;
#(
  parameter int NUM_GROUPS     = 20,
  parameter int RESERVED_GROUP = 1,
  parameter int CLEAR_GROUP    = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [GRP_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [NUM_GROUPS*FACT_N-1:0] hwReq,
  input  logic [LVL_W-1:0]             cpuMask,
  output logic                         irqOut,
  output logic [GRP_W-1:0]             irqGroup,
  output logic [LVL_W-1:0]             irqLevel
);
  wrStrobe_t strobe;
  logic      rdHit;

  irq_grp_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .RESERVED_GROUP(RESERVED_GROUP), .CLEAR_GROUP(CLEAR_GROUP)
  ) ctrl_i (
    .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData), .strobe(strobe), .rdHit(rdHit)
  );

  irq_grp_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .RESERVED_GROUP(RESERVED_GROUP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hwReq(hwReq), .cpuMask(cpuMask),
    .regAddr(regAddr), .rdHit(rdHit), .rdData(rdData),
    .irqOut(irqOut), .irqGroup(irqGroup), .irqLevel(irqLevel)
  );
endmodule

// File: rtl/irq_group_arbiter_chk.sv
module irq_group_arbiter_chk
  import irq_grp_pkg::*;
#(
  parameter int NUM_GROUPS     = 20,
  parameter int RESERVED_GROUP = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [GRP_W-1:0]  regAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [LVL_W-1:0]  cpuMask,
  input logic              irqOut,
  input logic [GRP_W-1:0]  irqGroup,
  input logic [LVL_W-1:0]  irqLevel
);
  // R1: a granted level is strictly below the mask seen one edge earlier
  a_r1_below_mask: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqLevel < $past(cpuMask)));

  // R9: idle outputs carry zeros
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (irqGroup == '0 && irqLevel == '0));

  // R8: winner never names the reserved slot or a missing group
  a_r8_valid_group: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((int'(irqGroup) < NUM_GROUPS) && (int'(irqGroup) != RESERVED_GROUP)));

  // R8: reserved and out-of-range addresses read zero
  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(regAddr) == RESERVED_GROUP) || (int'(regAddr) >= NUM_GROUPS)) |-> (rdData == '0));

  // R4: no request is presented on the edge following a reset cycle
  a_r4_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !irqOut);

  // R10: top bit of every word reads zero
  a_r10_top_bit_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1] == 1'b0);
endmodule

bind irq_group_arbiter irq_group_arbiter_chk #(
  .NUM_GROUPS(NUM_GROUPS), .RESERVED_GROUP(RESERVED_GROUP)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdData(rdData), .cpuMask(cpuMask),
  .irqOut(irqOut), .irqGroup(irqGroup), .irqLevel(irqLevel)
);

// File: tb/irq_group_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_group_arbiter_tb_top;
  localparam int NG = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [NG*4-1:0] hwReq = '0;
  logic [2:0]  cpuMask = '0;
  logic        irqOut;
  logic [4:0]  irqGroup;
  logic [2:0]  irqLevel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int mLev [NG];
  int mEn  [NG];
  int mReq [NG];

  always #10 clk = ~clk;

  irq_group_arbiter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .hwReq(hwReq), .cpuMask(cpuMask),
    .irqOut(irqOut), .irqGroup(irqGroup), .irqLevel(irqLevel)
  );

  function automatic bit liveAddr(int a);
    return (a < NG) && (a != 1);
  endfunction

  function automatic logic [15:0] expWord(int a);
    if (!liveAddr(a)) return 16'h0;
    return {1'b0, 3'(mLev[a]), 4'(mEn[a]), 4'(mReq[a]), 4'(mReq[a] & mEn[a])};
  endfunction

  function automatic logic [8:0] expIrq(int mask);
    int bl;
    int bg;
    bit f;
    f = 0; bl = 0; bg = 0;
    for (int g = 0; g < NG; g++) begin
      if (liveAddr(g) && ((mReq[g] & mEn[g]) != 0) && (mLev[g] < mask)) begin
        if (!f || mLev[g] < bl) begin f = 1; bl = mLev[g]; bg = g; end
      end
    end
    return {f, 5'(bg), 3'(bl)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOut(string tag);
    logic [8:0] e;
    e = expIrq(int'(cpuMask));
    check(tag, {23'd0, irqOut, irqGroup, irqLevel}, {23'd0, e});
  endtask

  task automatic checkRead(int a, string tag);
    regAddr = 5'(a);
    #1;
    check(tag, {16'd0, rdData}, {16'd0, expWord(a)});
  endtask

  // one access cycle: write and/or hardware pulses, model updated per requirements
  task automatic access(bit doWr, int a, logic [15:0] d, logic [NG*4-1:0] hw);
    @(negedge clk);
    wrEn = doWr; regAddr = 5'(a); wrData = d; hwReq = hw;
    @(negedge clk);
    wrEn = 1'b0; hwReq = '0;
    if (doWr && liveAddr(a)) begin
      int m;
      m = int'(d[3:0]);
      mLev[a] = int'(d[14:12]);
      mEn[a]  = int'(d[11:8]);
      if (a == 0) mReq[a] = mReq[a] & ~m;                      // R6
      else mReq[a] = (mReq[a] & ~m) | (int'(d[7:4]) & m);     // R5
    end
    for (int g = 0; g < NG; g++)
      if (liveAddr(g)) mReq[g] = mReq[g] | int'(hw[g*4 +: 4]); // R7
    @(negedge clk);  // output register catches up (R9)
  endtask

  task automatic setMask(int m);
    @(negedge clk);
    cpuMask = 3'(m);
    @(negedge clk);
  endtask

  function automatic logic [NG*4-1:0] hwBit(int g, int f);
    logic [NG*4-1:0] v;
    v = '0;
    v[g*4+f] = 1'b1;
    return v;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < NG; g++) begin mLev[g] = 0; mEn[g] = 0; mReq[g] = 0; end
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 outputs in reset", {29'd0, irqOut, irqLevel}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R4 outputs after reset");
    checkRead(5, "R4 group5 word");
    checkRead(0, "R4 group0 word");

    // R10 / R1 / R3: group 3 level 2, factor 0 enabled and pending
    cpuMask = 3'd7;
    access(1, 3, 16'h2111, '0);
    checkRead(3, "R10 group3 layout");
    checkOut("R1 group3 below mask");
    check("R1 group3 wins", {27'd0, irqGroup}, 32'd3);

    // R1 boundary: level equal to mask blocked
    setMask(2);
    checkOut("R1 level equals mask");
    check("R1 blocked", {31'd0, irqOut}, 32'd0);
    setMask(3);
    checkOut("R1 mask one above level");

    // R3: pending but not enabled is invisible
    setMask(7);
    access(1, 4, 16'h0000, '0);
    access(0, 0, '0, hwBit(4, 2));
    checkRead(4, "R3 detect zero without enable");
    checkOut("R3 disabled factor");

    // R2: tie on level 2 between group 3 and 5
    access(1, 5, 16'h2200, hwBit(5, 1));
    checkOut("R2 tie lower group");
    check("R2 tie group3", {27'd0, irqGroup}, 32'd3);
    access(1, 6, 16'h1F00, hwBit(6, 3));
    checkOut("R2 smaller level wins");

    // R5: masked write only touches detect-selected bits
    access(0, 0, '0, hwBit(6, 0) | hwBit(6, 1) | hwBit(6, 2));
    access(1, 6, 16'h1F02, '0);
    checkRead(6, "R5 only bit1 cleared");
    access(1, 6, 16'h1F24, '0);
    checkRead(6, "R5 bit2 written to zero, bit1 untouched");
    access(1, 6, 16'h1F22, '0);
    checkRead(6, "R5 bit1 written back to one");
    checkOut("R5 output after masked writes");

    // R6: group 0 write-one-to-clear
    access(1, 0, 16'h0300, hwBit(0, 0) | hwBit(0, 1));
    checkRead(0, "R6 group0 set");
    access(1, 0, 16'h03F1, '0);
    checkRead(0, "R6 clear bit0 only");
    access(1, 0, 16'h0300, '0);
    checkRead(0, "R6 zero detect leaves bit1");
    checkOut("R6 group0 level0 wins");

    // R7: hardware set beats simultaneous clear
    access(1, 0, 16'h0302, hwBit(0, 1));
    checkRead(0, "R7 set beats clear");
    access(1, 7, 16'h3F0F, hwBit(7, 2));
    checkRead(7, "R7 set beats masked zero write");

    // R8: holes
    access(1, 1, 16'h7FFF, hwBit(1, 0));
    checkRead(1, "R8 reserved group");
    access(1, 25, 16'h7FFF, '0);
    checkRead(25, "R8 out of range");
    access(1, 0, 16'h000F, '0);
    setMask(0);
    checkOut("R9 mask zero idle");
    check("R9 idle zeros", {23'd0, irqOut, irqGroup, irqLevel}, 32'd0);
    setMask(7);
    checkOut("R9 restore");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [15:0] d;
      logic [NG*4-1:0] hw;
      a = int'($urandom_range(0, 21));
      d = 16'($urandom());
      hw = '0;
      if ($urandom_range(0, 2) == 0) hw = hwBit(int'($urandom_range(0, NG-1)), int'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) == 0) cpuMask = 3'($urandom_range(0, 7));
      access($urandom_range(0, 3) != 0, a, d, hw);
      checkRead(a, "R5 R6 R7 random word");
      checkOut("R1 R2 R9 random arbitration");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule